// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device-side logic of a serial flash that answers continuous read commands over SPI mode 0. It runs on a fast system clock and brings the serial clock, select and data-in pins into that clock domain through a synchronizer. It takes in an 8-bit command code, then a 24-bit start address and, depending on the code, zero, one or two don't-care bytes. From then on it streams array bytes out on the serial data output, most significant bit first, for as long as the host keeps clocking.

Array bytes come from a synchronous memory read port: a one-cycle read strobe with an address, and the byte appears one system clock later. The block reads each byte ahead of time, so the byte is in a holding register before the byte in front of it has finished shifting out. The byte address steps by one after every byte and rolls over from the top of the 8 MiB array to zero without a gap.

Raising the select line drops the output enable at once through a combinational gate. The synchronized copy of the select line then clears the command logic, so the next select assertion starts a new command.

Top module: `sflash_rd_responder`

## Requirements
- R1: Command code 03h is followed by no don't-care byte, 0Bh by exactly one, and 1Bh by exactly two. These bytes come after the 24 address bits and before the first data bit.
- R2: The address is received as 24 bits, most significant bit first. Only the low 23 bits select a byte, so a set bit 23 reads the same byte as the address with that bit clear.
- R3: The first data bit is driven after the serial-clock falling edge that follows the last address or don't-care bit, and is valid at the next rising edge. Each byte goes out most significant bit first, with so_oe high for every data bit.
- R4: The byte address steps by one after each byte, so successive bytes on the output are the memory contents at start, start+1, start+2 and so on, with no idle bit between them.
- R5: After byte 7FFFFFh the stream continues with byte 000000h on the very next bit slot.
- R6: Raising cs_n forces so_oe low in the same instant, even partway through a byte. A later command after cs_n returns low is decoded from a fresh command byte.
- R7: so_oe is low after reset and while the command, address and don't-care bits are being received.
- R8: Any command code other than 03h, 0Bh or 1Bh leaves so_oe low and issues no memory read until cs_n rises.
- R9: Each memory read is a single-cycle mem_rd_en pulse. A read that is not cut short issues exactly one read for each byte begun plus one read-ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host (mode 0) |
| cs_n | input | 1 | Active-low chip select from the host |
| si | input | 1 | Serial data from the host, sampled on rising sck |
| so_data | output | 1 | Serial data to the host, changes after falling sck |
| so_oe | output | 1 | Output enable for the so pad; low means high impedance |
| mem_rd_en | output | 1 | Single-cycle read strobe to the array |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Array byte, valid one clk after the strobe |

## Verification
The read-ahead of the next byte and the end of the current byte can land close together: the fetch is issued when a byte is loaded into the shifter, and it must return before the next load. The bench checks this for every byte of long streams, including the roll-over from 7FFFFFh to zero. It judges each received byte against an array model computed by a bench function. A second collision is a select release that arrives in the middle of a byte while a read-ahead is in flight. Random cut points provoke it, and the bench judges it by an immediate so_oe check and by a clean decode of the next command.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_IGNORE
   } sfr_state_e;

   localparam logic [7:0] CODE_SLOW  = 8'h03;
   localparam logic [7:0] CODE_FAST  = 8'h0B;
   localparam logic [7:0] CODE_MAXF  = 8'h1B;

   function automatic logic code_known(input logic [7:0] code);
      return (code == CODE_SLOW) || (code == CODE_FAST) || (code == CODE_MAXF);
   endfunction

   function automatic logic [1:0] pad_bytes(input logic [7:0] code);
      case (code)
         CODE_FAST: return 2'd1;
         CODE_MAXF: return 2'd2;
         default:   return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("sfr_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [W-1:0] r [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) r[i] <= RST_VAL;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sfr_cmd_fsm.sv
module sfr_cmd_fsm
   import sfr_pkg::*;
#(
   parameter int ADDR_W     = 23,
   parameter int ADDR_BYTES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              si_s,
   output logic              sck_fall,
   output logic              start,
   output logic [ADDR_W-1:0] start_addr,
   output sfr_state_e        state
);

   localparam int BC_W = $clog2(ADDR_BYTES + 1);
   localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(ADDR_BYTES - 1);

   sfr_state_e        state_q;
   logic              sck_q;
   logic              sck_rise;
   logic [2:0]        bitcnt;
   logic [BC_W-1:0]   bytecnt;
   logic [1:0]        pads_left;
   logic [ADDR_W-1:0] sh;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] addr_q;
   logic              start_q;
   logic              byte_end;

   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;
   assign nxt      = {sh[ADDR_W-2:0], si_s};
   assign byte_end = (bitcnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         state_q   <= ST_OPC;
         bitcnt    <= '0;
         bytecnt   <= '0;
         pads_left <= '0;
         sh        <= '0;
         addr_q    <= '0;
         start_q   <= 1'b0;
      end else begin
         sck_q   <= sck_s;
         start_q <= 1'b0;
         if (cs_n_s) begin
            state_q <= ST_OPC;
            bitcnt  <= '0;
            bytecnt <= '0;
         end else if (sck_rise) begin
            sh     <= nxt;
            bitcnt <= bitcnt + 3'd1;
            if (byte_end) begin
               case (state_q)
                  ST_OPC: begin
                     if (code_known(nxt[7:0])) begin
                        state_q   <= ST_ADDR;
                        pads_left <= pad_bytes(nxt[7:0]);
                        bytecnt   <= '0;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
                  ST_ADDR: begin
                     bytecnt <= bytecnt + 1'b1;
                     if (bytecnt == LAST_BYTE) begin
                        addr_q <= nxt;
                        if (pads_left == 2'd0) begin
                           state_q <= ST_DATA;
                           start_q <= 1'b1;
                        end else begin
                           state_q <= ST_DUMMY;
                        end
                     end
                  end
                  ST_DUMMY: begin
                     pads_left <= pads_left - 2'd1;
                     if (pads_left == 2'd1) begin
                        state_q <= ST_DATA;
                        start_q <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign start      = start_q;
   assign start_addr = addr_q;
   assign state      = state_q;

endmodule

// File: rtl/sfr_stream.sv
module sfr_stream #(
   parameter int ADDR_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              sck_fall,
   input  logic [7:0]        mem_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              so_bit,
   output logic              drive
);

   logic              armed;
   logic              drive_q;
   logic [2:0]        bitpos;
   logic [7:0]        tx_sh;
   logic [7:0]        hold;
   logic              rd_q;
   logic              rd_wait;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] next_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         drive_q   <= 1'b0;
         bitpos    <= '0;
         tx_sh     <= '0;
         hold      <= '0;
         rd_q      <= 1'b0;
         rd_wait   <= 1'b0;
         addr_q    <= '0;
         next_addr <= '0;
      end else begin
         rd_q    <= 1'b0;
         rd_wait <= rd_q;
         if (rd_wait) hold <= mem_rdata;
         if (abort) begin
            armed   <= 1'b0;
            drive_q <= 1'b0;
            bitpos  <= '0;
         end else if (start) begin
            armed     <= 1'b1;
            bitpos    <= '0;
            rd_q      <= 1'b1;
            addr_q    <= start_addr;
            next_addr <= start_addr + 1'b1;
         end else if (sck_fall && armed) begin
            drive_q <= 1'b1;
            bitpos  <= bitpos + 3'd1;
            if (bitpos == 3'd0) begin
               tx_sh     <= hold;
               rd_q      <= 1'b1;
               addr_q    <= next_addr;
               next_addr <= next_addr + 1'b1;
            end else begin
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

   assign mem_rd_en = rd_q;
   assign mem_addr  = addr_q;
   assign so_bit    = tx_sh[7];
   assign drive     = drive_q;

endmodule

// File: rtl/sflash_rd_responder.sv
module sflash_rd_responder
   import sfr_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int ADDR_BYTES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              si,
   output logic              so_data,
   output logic              so_oe,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata
);

   generate
      if (ADDR_W < 8 || ADDR_W > ADDR_BYTES * 8) begin : g_bad_addr
         $error("sflash_rd_responder: ADDR_W must lie in 8..ADDR_BYTES*8");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              sck_s, cs_n_s, si_s;
   logic              sck_fall;
   logic              start;
   logic [ADDR_W-1:0] start_addr;
   logic              drive;
   sfr_state_e        st;

   sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({si, cs_n, sck}),
      .q     (pins_s)
   );

   assign sck_s  = pins_s[0];
   assign cs_n_s = pins_s[1];
   assign si_s   = pins_s[2];

   sfr_cmd_fsm #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (sck_s),
      .cs_n_s     (cs_n_s),
      .si_s       (si_s),
      .sck_fall   (sck_fall),
      .start      (start),
      .start_addr (start_addr),
      .state      (st)
   );

   sfr_stream #(.ADDR_W(ADDR_W)) u_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (cs_n_s),
      .start      (start),
      .start_addr (start_addr),
      .sck_fall   (sck_fall),
      .mem_rdata  (mem_rdata),
      .mem_rd_en  (mem_rd_en),
      .mem_addr   (mem_addr),
      .so_bit     (so_data),
      .drive      (drive)
   );

   assign so_oe = drive & ~cs_n;

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
   import sfr_pkg::*;
#(
   parameter int ADDR_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              so_oe,
   input logic              so_data,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              sck_fall,
   input sfr_state_e        st
);

   logic              run_q;
   logic [ADDR_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         last_q <= '0;
      end else if (cs_n) begin
         run_q <= 1'b0;
      end else if (mem_rd_en) begin
         run_q  <= 1'b1;
         last_q <= mem_addr;
      end
   end

   assert_quiet_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_DATA) |-> !so_oe);

   assert_ignored_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !mem_rd_en);

   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_bit_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && !sck_fall) |=> $stable(so_data));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && run_q && !cs_n) |-> (mem_addr == last_q + 1'b1));

   assert_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && run_q && !cs_n && (last_q == {ADDR_W{1'b1}})) |-> (mem_addr == '0));

endmodule

bind sflash_rd_responder sfr_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .so_oe     (so_oe),
   .so_data   (so_data),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .sck_fall  (sck_fall),
   .st        (st)
);

// File: tb/sim_sflash_rd_responder.sv
`timescale 1ns/1ps
module sim_sflash_rd_responder;

   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        si = 1'b0;
   logic        so_data, so_oe, mem_rd_en;
   logic [22:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;
   int rd_total = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sflash_rd_responder u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .so_data(so_data), .so_oe(so_oe), .mem_rd_en(mem_rd_en),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] pat(input logic [22:0] a);
      return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h5A;
   endfunction

   function automatic int pads(input logic [7:0] op);
      if (op == 8'h0B) return 1;
      if (op == 8'h1B) return 2;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= pat(mem_addr);
         rd_total  <= rd_total + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic s, output logic oe);
      @(negedge clk);
      sck = 1'b0;
      si  = b;
      repeat (H) @(negedge clk);
      s   = so_data;
      oe  = so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic run_read(input logic [7:0] op, input logic [23:0] addr, input int nb,
                           input int cut, input string tag);
      logic s, oe;
      bit hdr_bad = 1'b0;
      bit dat_bad = 1'b0;
      bit ok_op;
      int base;
      logic [7:0] got;
      logic [7:0] exp;
      logic [22:0] a;
      ok_op = (op == 8'h03) || (op == 8'h0B) || (op == 8'h1B);
      base  = rd_total;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         send_bit(op[i], s, oe);
         if (oe) hdr_bad = 1'b1;
      end
      for (int i = 23; i >= 0; i--) begin
         send_bit(addr[i], s, oe);
         if (oe) hdr_bad = 1'b1;
      end
      for (int i = 0; i < pads(op) * 8; i++) begin
         send_bit(1'($urandom), s, oe);
         if (oe) hdr_bad = 1'b1;
      end
      check(!hdr_bad, "R7 output quiet in header", 32'(hdr_bad), 0);
      if (!ok_op) begin
         for (int i = 0; i < nb * 8; i++) begin
            send_bit(1'($urandom), s, oe);
            if (oe) dat_bad = 1'b1;
         end
         check(!dat_bad, "R8 unknown code never drives", 32'(dat_bad), 0);
         check(rd_total == base, "R8 unknown code never reads", 32'(rd_total - base), 0);
      end else begin
         for (int b = 0; b < nb; b++) begin
            got = 8'h00;
            for (int k = 0; k < 8; k++) begin
               send_bit(1'($urandom), s, oe);
               got = {got[6:0], s};
               if (oe !== 1'b1) dat_bad = 1'b1;
            end
            a   = addr[22:0] + 23'(b);
            exp = pat(a);
            check(got == exp, tag, 32'(got), 32'(exp));
         end
         check(!dat_bad, "R3 output driven in data phase", 32'(dat_bad), 0);
         if (cut > 0) begin
            for (int k = 0; k < cut; k++) send_bit(1'($urandom), s, oe);
            @(negedge clk);
            cs_n = 1'b1;
            #1;
            check(so_oe == 1'b0, "R6 release mid byte", 32'(so_oe), 0);
         end
      end
      @(negedge clk);
      cs_n = 1'b1;
      sck  = 1'b0;
      repeat (8) @(negedge clk);
      if (ok_op)
         check((rd_total - base) == nb + (cut > 0 ? 1 : 0) + 1, "R9 one fetch per byte",
               32'(rd_total - base), 32'(nb + (cut > 0 ? 1 : 0) + 1));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R4 act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] op;
      int r;
      r = int'($urandom(32'h5EED));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(so_oe == 1'b0, "R7 reset output off", 32'(so_oe), 0);
      check(mem_rd_en == 1'b0, "R9 reset no strobe", 32'(mem_rd_en), 0);

      run_read(8'h03, 24'h000010, 3, 0, "R1 code 03h data");
      run_read(8'h0B, 24'h123456, 3, 0, "R1 code 0Bh data");
      run_read(8'h1B, 24'h2A0F0E, 3, 0, "R1 code 1Bh data");
      run_read(8'h03, 24'h800005, 2, 0, "R2 bit 23 ignored");
      run_read(8'h0B, 24'h7FFFFD, 5, 0, "R5 rollover to zero");
      run_read(8'h1B, 24'hFFFFFF, 3, 0, "R5 rollover with pads");
      run_read(8'h9F, 24'h000100, 2, 0, "R8 unknown code");
      run_read(8'h03, 24'h0000F0, 2, 3, "R6 cut mid byte");
      run_read(8'h03, 24'h000020, 2, 0, "R6 fresh command after cut");

      for (int t = 0; t < 36; t++) begin
         r = int'($urandom % 8);
         case (r)
            0:       op = 8'h9F;
            1, 2, 3: op = 8'h03;
            4, 5:    op = 8'h0B;
            default: op = 8'h1B;
         endcase
         run_read(op, 24'($urandom), 1 + int'($urandom % 4),
                  ($urandom % 3 == 0) ? 1 + int'($urandom % 7) : 0, "R4 random stream");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule